// File: doc/BRIEF.md
# Auto-Reload Timer With Split Mode

This block is a 16-bit up-counter with a 16-bit reload value. In full-width mode it advances once per count enable. When it passes its all-ones value it reloads and raises an overflow event. In split mode the two bytes act as two separate 8-bit timers. Each byte wraps into its own reload byte and raises its own overflow event, so one block can produce two periodic rates.

The count enable comes from one of three sources: every system clock, one clock in twelve from a free-running prescaler, or an external clock. The external clock is first brought into the system clock domain and then divided by eight. Software reaches a control byte, two count bytes and two reload bytes over a byte-wide register port. Overflows set sticky flags, which drive a single interrupt request through per-flag enables. One-cycle overflow pulses are also brought out so that other logic can use them as triggers.

Top module: `reload_timer`

## Requirements
- R1: After reset every register (control, count, reload) reads 0. `irq_o`, `ovf_o` and `ovf_lo_o` are 0.
- R2: In full-width mode (control bit1 = 0), the 16-bit count advances by one on each count enable while control bit0 (run) is 1, and holds while run is 0. On an enable at 0xFFFF it loads the 16-bit reload value, sets control bit7 and drives `ovf_o` high for one cycle.
- R3: In split mode (control bit1 = 1), the low count byte advances on every enable whatever the run bit is. On an enable at 0xFF it loads the low reload byte, sets control bit6 and pulses `ovf_lo_o` for one cycle.
- R4: In split mode the high count byte advances only while run is 1. On wrap it loads the high reload byte, sets control bit7 and pulses `ovf_o`.
- R5: Control bits 3:2 = 0 selects the system clock: one enable per clock.
- R6: Bits 3:2 = 1 selects a free-running prescaler that gives exactly one enable per 12 system clocks.
- R7: Bits 3:2 = 2 selects the external clock, synchronized through two flops and divided by 8. This gives one enable per 8 rising external edges, the first on the 4th edge after reset.
- R8: Bits 3:2 = 3 gives no enables, so the count holds.
- R9: `irq_o` is high when (bit7 and bit4) or (bit6 and bit5). Writing 0 to a flag bit clears it.
- R10: A write to a count byte takes effect at the next edge and overrides the increment of that byte in the same cycle. In full-width mode a write to either count byte also stalls the other byte for that cycle.
- R11: Reload bytes read back as written, and the next reload uses the new value.
- R12: Addresses: 0 control, 1 count low, 2 count high, 3 reload low, 4 reload high. Addresses 5 to 7 read 0 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External clock, asynchronous |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |
| ovf_o | output | 1 | One-cycle pulse on a full-width or high-byte overflow |
| ovf_lo_o | output | 1 | One-cycle pulse on a low-byte overflow in split mode |

## Verification
The bench sets the count just below the wrap point and checks that the next enable loads the reload value rather than zero. A design that wraps to zero, or that reloads one cycle late, fails these checks. It checks that the carry from the low byte reaches the high byte in full-width mode, and that in split mode the high byte stays frozen while run is 0. A design that does not fully separate the two halves fails here. A count-byte write made while the counter runs must land exactly, and must stall the other byte, so a design that lets the increment win ends one count high. The prescaled sources are checked over exact windows: 120 clocks must give ten counts, and 16 external edges must give two.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_DIV12 = 2'd1,
    SRC_EXT8  = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;

  typedef struct packed {
    logic flag_hi;
    logic flag_lo;
    logic ie_lo;
    logic ie_hi;
    src_e src;
    logic split;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen
  import rt_pkg::*;
#(
  parameter int PRE_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  src_e src_i,
  output logic tick_o
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int EXT_W = $clog2(EXT_DIV);

  logic [PRE_W-1:0]       pre_q;
  logic                   pre_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   ext_rise;
  logic [EXT_W-1:0]       ext_cnt_q;
  logic                   ext_tick;

  assign pre_tick = (pre_q == PRE_W'(PRE_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if (pre_tick) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      ext_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev_q;
  // divided clock is the counter MSB; its rising edge is the enable
  assign ext_tick = ext_rise && (ext_cnt_q == EXT_W'(EXT_DIV/2 - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_cnt_q <= '0;
    else if (ext_rise) ext_cnt_q <= ext_cnt_q + 1'b1;
  end

  always_comb begin
    unique case (src_i)
      SRC_SYS:   tick_o = 1'b1;
      SRC_DIV12: tick_o = pre_tick;
      SRC_EXT8:  tick_o = ext_tick;
      default:   tick_o = 1'b0;
    endcase
  end

  AST_PRE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick |=> !pre_tick); // R6
  AST_EXT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_tick |=> !ext_tick); // R7
  AST_EXT_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_tick |-> $past(sync_q[SYNC_STAGES-2])); // R7
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int HALF_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                run_i,
  input  logic                split_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic [2*HALF_W-1:0] rld_i,
  output logic [2*HALF_W-1:0] cnt_o,
  output logic                evt_hi_o,
  output logic                evt_lo_o
);
  localparam int W = 2 * HALF_W;

  logic [W-1:0] cnt_q, cnt_d;
  logic         full_max, lo_max, hi_max;
  logic         step_full, step_lo, step_hi;

  assign full_max  = &cnt_q;
  assign lo_max    = &cnt_q[HALF_W-1:0];
  assign hi_max    = &cnt_q[W-1:HALF_W];
  assign step_full = !split_i && run_i && tick_i && !wr_lo_i && !wr_hi_i;
  assign step_lo   = split_i && tick_i && !wr_lo_i;
  assign step_hi   = split_i && run_i && tick_i && !wr_hi_i;
  assign evt_hi_o  = (step_full && full_max) || (step_hi && hi_max);
  assign evt_lo_o  = step_lo && lo_max;

  always_comb begin
    cnt_d = cnt_q;
    if (step_full) cnt_d = full_max ? rld_i : cnt_q + 1'b1;
    if (step_lo)
      cnt_d[HALF_W-1:0] = lo_max ? rld_i[HALF_W-1:0] : cnt_q[HALF_W-1:0] + 1'b1;
    if (step_hi)
      cnt_d[W-1:HALF_W] = hi_max ? rld_i[W-1:HALF_W] : cnt_q[W-1:HALF_W] + 1'b1;
    if (wr_lo_i) cnt_d[HALF_W-1:0] = wdata_i;
    if (wr_hi_i) cnt_d[W-1:HALF_W] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_FULL_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_full && full_max) |=> (cnt_q == $past(rld_i))); // R2
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_i && !run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q)); // R2
  AST_LO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && tick_i && lo_max && !wr_lo_i) |=>
      (cnt_q[HALF_W-1:0] == $past(rld_i[HALF_W-1:0]))); // R3
  AST_HI_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && !run_i && !wr_hi_i) |=> $stable(cnt_q[W-1:HALF_W])); // R4
  AST_WR_LO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cnt_q[HALF_W-1:0] == $past(wdata_i))); // R10
  AST_WR_HI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (cnt_q[W-1:HALF_W] == $past(wdata_i))); // R10
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int PRE_DIV = 12,
  parameter int EXT_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              ovf_lo_o
);
  localparam int CNT_W = 2 * BYTE_W;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt;
  logic             tick, evt_hi, evt_lo;
  logic             wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi;
  logic             ovf_q, ovf_lo_q;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_cnt_lo = wr_en_i && (addr_i == A_CNT_LO);
  assign wr_cnt_hi = wr_en_i && (addr_i == A_CNT_HI);
  assign wr_rld_lo = wr_en_i && (addr_i == A_RLD_LO);
  assign wr_rld_hi = wr_en_i && (addr_i == A_RLD_HI);

  rt_tick_gen #(.PRE_DIV(PRE_DIV), .EXT_DIV(EXT_DIV), .SYNC_STAGES(2)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_clk_i(ext_clk_i),
    .src_i    (ctrl_q.src),
    .tick_o   (tick)
  );

  rt_counter #(.HALF_W(BYTE_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .run_i   (ctrl_q.run),
    .split_i (ctrl_q.split),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .wdata_i (wdata_i),
    .rld_i   (rld_q),
    .cnt_o   (cnt),
    .evt_hi_o(evt_hi),
    .evt_lo_o(evt_lo)
  );

  // hardware flag set takes precedence over a software clear
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata_i);
    if (evt_hi)  ctrl_d.flag_hi = 1'b1;
    if (evt_lo)  ctrl_d.flag_lo = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      rld_q    <= '0;
      ovf_q    <= 1'b0;
      ovf_lo_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      ovf_q    <= evt_hi;
      ovf_lo_q <= evt_lo;
      if (wr_rld_lo) rld_q[BYTE_W-1:0]     <= wdata_i;
      if (wr_rld_hi) rld_q[CNT_W-1:BYTE_W] <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rdata_o = ctrl_q;
      A_CNT_LO: rdata_o = cnt[BYTE_W-1:0];
      A_CNT_HI: rdata_o = cnt[CNT_W-1:BYTE_W];
      A_RLD_LO: rdata_o = rld_q[BYTE_W-1:0];
      A_RLD_HI: rdata_o = rld_q[CNT_W-1:BYTE_W];
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o    = (ctrl_q.flag_hi & ctrl_q.ie_hi) | (ctrl_q.flag_lo & ctrl_q.ie_lo);
  assign ovf_o    = ovf_q;
  assign ovf_lo_o = ovf_lo_q;

  AST_FLAG_HI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> ctrl_q.flag_hi); // R9
  AST_FLAG_LO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_lo_o |-> ctrl_q.flag_lo); // R9
  AST_LO_PULSE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_lo_o |-> $past(ctrl_q.split)); // R3
  AST_UNMAPPED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i > A_RLD_HI) |=> $stable(rld_q)); // R12
endmodule

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, ovf_o, ovf_lo_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  reload_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .ovf_o(ovf_o), .ovf_lo_o(ovf_lo_o)
  );

  // {ctrl, count init, reload, cycles, expected count}, system clock source
  localparam logic [71:0] VEC [6] = '{
    {8'h01, 16'h0000, 16'h0000, 16'd10, 16'h000A},  // R2 R5 plain count
    {8'h01, 16'hFFFD, 16'h1234, 16'd5,  16'h1236},  // R2 R11 wrap to reload
    {8'h02, 16'h55FE, 16'h9980, 16'd4,  16'h5582},  // R3 R4 low only
    {8'h03, 16'hFEFF, 16'h1010, 16'd3,  16'h1112},  // R3 R4 both halves
    {8'h01, 16'h00FF, 16'h0000, 16'd1,  16'h0100},  // R2 carry into high
    {8'h0D, 16'h1234, 16'h0000, 16'd20, 16'h1234}   // R8 source off
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #0.2;
    d = rdata_o;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic setup(input logic [15:0] init, input logic [15:0] rld);
    wr(3'd0, 8'h00);
    wr(3'd3, rld[7:0]);
    wr(3'd4, rld[15:8]);
    wr(3'd1, init[7:0]);
    wr(3'd2, init[15:8]);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      chk("R1 reg reset", {8'h0, b}, 16'h0);
    end
    chk("R1 outputs reset", {13'h0, irq_o, ovf_o, ovf_lo_o}, 16'h0);

    // table walk
    for (int i = 0; i < 6; i++) begin
      setup(VEC[i][63:48], VEC[i][47:32]);
      wr(3'd0, VEC[i][71:64]);
      repeat (int'(VEC[i][31:16])) @(posedge clk_i);
      @(negedge clk_i);
      rd16(v);
      chk($sformatf("R2 R3 R4 R8 vector %0d", i), v, VEC[i][15:0]);
    end

    // R2 R9: full-width overflow pulse, flag, irq, clear
    setup(16'hFFFE, 16'h00F0);
    wr(3'd0, 8'h11);
    chk("R2 no pulse before wrap", {15'h0, ovf_o}, 16'h0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R2 no pulse at FFFF", {15'h0, ovf_o}, 16'h0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R2 pulse on wrap", {15'h0, ovf_o}, 16'h1);
    chk("R9 irq on flag", {15'h0, irq_o}, 16'h1);
    rd16(v);
    chk("R2 reload loaded", v, 16'h00F0);
    rd(3'd0, b);
    chk("R2 flag hi set", {8'h0, b}, 16'h0091);
    @(posedge clk_i); @(negedge clk_i);
    chk("R2 pulse one cycle", {15'h0, ovf_o}, 16'h0);
    chk("R9 irq sticky", {15'h0, irq_o}, 16'h1);
    wr(3'd0, 8'h10);
    chk("R9 irq cleared", {15'h0, irq_o}, 16'h0);
    rd(3'd0, b);
    chk("R9 flag cleared", {8'h0, b}, 16'h0010);

    // R3 R4 R9: split low overflow with run off
    setup(16'h40FF, 16'h0007);
    wr(3'd0, 8'h22);
    @(posedge clk_i); @(negedge clk_i);
    chk("R3 low pulse", {14'h0, ovf_o, ovf_lo_o}, 16'h1);
    chk("R9 irq from low", {15'h0, irq_o}, 16'h1);
    rd(3'd0, b);
    chk("R3 flag lo set", {8'h0, b}, 16'h0062);
    rd16(v);
    chk("R3 low reload", v, 16'h4007);
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    rd(3'd2, b);
    chk("R4 high frozen without run", {8'h0, b}, 16'h0040);
    wr(3'd0, 8'h00);

    // R6 divide by 12
    setup(16'h0000, 16'h0000);
    wr(3'd0, 8'h05);
    repeat (120) @(posedge clk_i);
    @(negedge clk_i);
    rd16(v);
    chk("R6 ten ticks in 120 clocks", v, 16'd10);

    // R7 external clock divided by 8
    setup(16'h0000, 16'h0000);
    wr(3'd0, 8'h09);
    for (int k = 0; k < 16; k++) begin
      ext_clk_i = 1'b1;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i) ext_clk_i = 1'b0;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
    end
    repeat (6) @(posedge clk_i);
    @(negedge clk_i);
    rd16(v);
    chk("R7 two ticks in 16 edges", v, 16'd2);

    // R10 write beats increment, and stalls other byte
    setup(16'h2200, 16'h0000);
    wr(3'd0, 8'h01);
    repeat (3) @(posedge clk_i);
    wr(3'd1, 8'h80);
    rd16(v);
    chk("R10 low write exact", v, 16'h2280);
    wr(3'd2, 8'h55);
    rd16(v);
    chk("R10 high write stalls low", v, 16'h5581);
    wr(3'd0, 8'h00);

    // R11 reload readback
    wr(3'd3, 8'hAB);
    wr(3'd4, 8'hCD);
    rd(3'd3, b); v[7:0] = b;
    rd(3'd4, b); v[15:8] = b;
    chk("R11 reload readback", v, 16'hCDAB);

    // R12 unmapped address
    wr(3'd5, 8'hFF);
    rd(3'd5, b);
    chk("R12 unmapped reads zero", {8'h0, b}, 16'h0);
    rd(3'd3, b);
    chk("R12 reload untouched", {8'h0, b}, 16'h00AB);
    rd(3'd0, b);
    chk("R12 control untouched", {8'h0, b}, 16'h0000);

    summary();
    $finish;
  end
endmodule